// File: doc/BRIEF.md
# Programmable Frequency Output Divider

This block produces the level and drive enable of a frequency output pin. One of four source rates is chosen (the base 32.768 kHz rate or the 1024 Hz, 32 Hz and 1 Hz rates). That source is divided by one of eight ratios, and each ratio has its own fixed duty cycle. A control pin can override the selection and force a plain 32.768 kHz square wave. An enable bit and a chip-enable-high pin decide whether the pin drives at all. The pin is modelled as a data level plus an output enable, so the pad tristate stays outside the block.

The block runs on a clock of twice 32.768 kHz, so that one clock cycle is one half period of the base rate. The slower sources arrive as single-cycle strobes, and each strobe marks one half period of its rate: 2048, 64 and 2 strobes per second for the 1024 Hz, 32 Hz and 1 Hz sources. The divider counts source half periods in one phase counter and drives its output high for the first part of each period.

Top module: `fout_divider`

## Requirements
- R1: While reset is asserted, and until the first clock after it is released, both the divided level and the fixed square-wave level are 0. With the pin driving, `fout_data` is therefore 0.
- R2: `src_sel` picks the half-period strobe that advances the divider. Code 00 uses every clock (32.768 kHz), 01 uses `tick_1k`, 10 uses `tick_32` and 11 uses `tick_1`. Strobes of sources that are not selected leave the divided output unchanged.
- R3: `ratio_sel` codes 000 to 111 divide the source by 1, 2, 3, 6, 5, 10, 15 and 30. One output period lasts twice the ratio in source half periods.
- R4: Ratios 1, 2, 6, 10 and 30 give 50% duty: the output is high for as many source half periods as the ratio.
- R5: Ratio 3 is high for 2 of 6 half periods and ratio 15 for 10 of 30 (duty 1/3). Ratio 5 is high for 2 of 10 (duty 1/5). Every period starts with its high part.
- R6: When `ce_hi` is 0, `fout_oe` and `fout_data` are both 0 whatever the other inputs hold.
- R7: When `ce_hi` is 1 and `ctl_pin` is 0, `fout_oe` is 1 and `fout_data` toggles on every clock (a 32.768 kHz square wave), regardless of `src_sel`, `ratio_sel` and `en_bit`.
- R8: When `ce_hi` and `ctl_pin` are both 1, an `en_bit` of 1 drives the divided level with `fout_oe` at 1, and an `en_bit` of 0 gives `fout_oe` and `fout_data` of 0.
- R9: A change of `src_sel` or `ratio_sel` forces the divided level low on the next clock and restarts the phase. A source strobe in the same cycle as the change is discarded, and the next strobe begins a fresh period with its high part.
- R10: Ratio 1 on a slow source gives a square wave that changes level on every source strobe, so its period is two strobes at 50% duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Clock at 65.536 kHz; one cycle is a half period of 32.768 kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | Half-period strobe of the 1024 Hz source |
| tick_32 | input | 1 | Half-period strobe of the 32 Hz source |
| tick_1 | input | 1 | Half-period strobe of the 1 Hz source |
| src_sel | input | 2 | Source rate select |
| ratio_sel | input | 3 | Division ratio select |
| en_bit | input | 1 | Divided-output enable bit |
| ctl_pin | input | 1 | Override control pin; 0 forces the fixed 32.768 kHz output |
| ce_hi | input | 1 | Chip-enable-high pin; 0 releases the output |
| fout_data | output | 1 | Output level |
| fout_oe | output | 1 | Output drive enable |

## Verification
A selection change and a strobe of the selected source can land in the same clock. The change must win: the strobe is lost, the level drops and the next strobe opens a new high phase. The bench provokes this on purpose by driving the 1 Hz strobe by hand and rewriting the ratio in that exact cycle. With free-running strobes the same collision also happens incidentally while the selection sweeps. Each case is judged by a behavioural reference model that is compared every clock, and by directed checks of the level in the cycles after the collision.

// File: rtl/fout_pkg.sv
package fout_pkg;

    localparam int SRC_W      = 2;
    localparam int RATIO_W    = 3;
    localparam int SEL_W      = SRC_W + RATIO_W;
    localparam int MAX_RATIO  = 30;
    localparam int MAX_HALVES = 2 * MAX_RATIO;
    localparam int PHASE_W    = $clog2(MAX_HALVES);
    localparam int N_SLOW     = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_BASE = 2'b00,
        SRC_1K   = 2'b01,
        SRC_32   = 2'b10,
        SRC_1    = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        DUTY_HALF,
        DUTY_THIRD,
        DUTY_FIFTH
    } duty_e;

    typedef struct packed {
        logic [PHASE_W-1:0] last;
        logic [PHASE_W-1:0] high;
    } shape_t;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [PHASE_W-1:0] phase;
        logic               lvl;
    } div_state_t;

    typedef struct packed {
        logic fix;
    } pin_state_t;

    function automatic int ratio_of(input logic [RATIO_W-1:0] code);
        unique case (code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 3;
            3'd3: return 6;
            3'd4: return 5;
            3'd5: return 10;
            3'd6: return 15;
            default: return 30;
        endcase
    endfunction

    function automatic duty_e duty_of(input logic [RATIO_W-1:0] code);
        unique case (code)
            3'd2, 3'd6: return DUTY_THIRD;
            3'd4:       return DUTY_FIFTH;
            default:    return DUTY_HALF;
        endcase
    endfunction

    function automatic shape_t shape_of(input logic [RATIO_W-1:0] code);
        shape_t s;
        int     r;
        int     h;
        int     hi;
        r  = ratio_of(code);
        h  = 2 * r;
        unique case (duty_of(code))
            DUTY_THIRD: hi = h / 3;
            DUTY_FIFTH: hi = h / 5;
            default:    hi = r;
        endcase
        s.last = PHASE_W'(h - 1);
        s.high = PHASE_W'(hi);
        return s;
    endfunction

endpackage

// File: rtl/fout_src_pick.sv
module fout_src_pick
    import fout_pkg::*;
#(
    parameter int SLOW_N = N_SLOW
) (
    input  logic [SRC_W-1:0]  src_sel,
    input  logic [SLOW_N-1:0] slow_stb,
    output logic              src_stb
);

    always_comb begin
        unique case (src_e'(src_sel))
            SRC_BASE: src_stb = 1'b1;
            SRC_1K:   src_stb = slow_stb[0];
            SRC_32:   src_stb = slow_stb[1];
            default:  src_stb = slow_stb[SLOW_N-1];
        endcase
    end

endmodule

// File: rtl/fout_phase_div.sv
module fout_phase_div
    import fout_pkg::*;
(
    input  logic               clk_2x,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   src_sel,
    input  logic [RATIO_W-1:0] ratio_sel,
    input  logic               src_stb,
    output logic               div_lvl
);

    localparam shape_t RST_SHAPE = shape_of(RATIO_W'(0));

    div_state_t         st_d;
    div_state_t         st_q;
    shape_t             shp;
    logic [SEL_W-1:0]   cur_sel;
    logic [PHASE_W-1:0] nxt_phase;

    always_comb begin
        st_d      = st_q;
        shp       = shape_of(ratio_sel);
        cur_sel   = {src_sel, ratio_sel};
        nxt_phase = (st_q.phase >= shp.last) ? '0 : st_q.phase + 1'b1;
        if (cur_sel != st_q.sel) begin
            // selection change wins over a coincident strobe
            st_d.sel   = cur_sel;
            st_d.phase = shp.last;
            st_d.lvl   = 1'b0;
        end else if (src_stb) begin
            st_d.phase = nxt_phase;
            st_d.lvl   = (nxt_phase < shp.high);
        end
    end

    always_ff @(posedge clk_2x or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel   <= '0;
            st_q.phase <= RST_SHAPE.last;
            st_q.lvl   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_lvl = st_q.lvl;

endmodule

// File: rtl/fout_pin_mux.sv
module fout_pin_mux
    import fout_pkg::*;
(
    input  logic clk_2x,
    input  logic rst_n,
    input  logic ce_hi,
    input  logic ctl_pin,
    input  logic en_bit,
    input  logic div_lvl,
    output logic fout_data,
    output logic fout_oe
);

    pin_state_t ps_d;
    pin_state_t ps_q;

    always_comb begin
        ps_d     = ps_q;
        ps_d.fix = ~ps_q.fix;
    end

    always_ff @(posedge clk_2x or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    // priority: chip enable, then override pin, then enable bit
    always_comb begin
        fout_oe   = 1'b0;
        fout_data = 1'b0;
        if (ce_hi) begin
            if (!ctl_pin) begin
                fout_oe   = 1'b1;
                fout_data = ps_q.fix;
            end else if (en_bit) begin
                fout_oe   = 1'b1;
                fout_data = div_lvl;
            end
        end
    end

endmodule

// File: rtl/fout_divider.sv
module fout_divider
    import fout_pkg::*;
(
    input  logic               clk_2x,
    input  logic               rst_n,
    input  logic               tick_1k,
    input  logic               tick_32,
    input  logic               tick_1,
    input  logic [SRC_W-1:0]   src_sel,
    input  logic [RATIO_W-1:0] ratio_sel,
    input  logic               en_bit,
    input  logic               ctl_pin,
    input  logic               ce_hi,
    output logic               fout_data,
    output logic               fout_oe
);

    logic [N_SLOW-1:0] slow_stb;
    logic              src_stb;
    logic              div_lvl;

    assign slow_stb = {tick_1, tick_32, tick_1k};

    fout_src_pick #(
        .SLOW_N (N_SLOW)
    ) i_pick (
        .src_sel  (src_sel),
        .slow_stb (slow_stb),
        .src_stb  (src_stb)
    );

    fout_phase_div i_div (
        .clk_2x    (clk_2x),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .ratio_sel (ratio_sel),
        .src_stb   (src_stb),
        .div_lvl   (div_lvl)
    );

    fout_pin_mux i_mux (
        .clk_2x    (clk_2x),
        .rst_n     (rst_n),
        .ce_hi     (ce_hi),
        .ctl_pin   (ctl_pin),
        .en_bit    (en_bit),
        .div_lvl   (div_lvl),
        .fout_data (fout_data),
        .fout_oe   (fout_oe)
    );

endmodule

// File: rtl/fout_divider_chk.sv
module fout_divider_chk (
    input logic       clk_2x,
    input logic       rst_n,
    input logic       tick_1k,
    input logic       tick_32,
    input logic       tick_1,
    input logic [1:0] src_sel,
    input logic [2:0] ratio_sel,
    input logic       en_bit,
    input logic       ctl_pin,
    input logic       ce_hi,
    input logic       fout_data,
    input logic       fout_oe,
    input logic       div_lvl
);

    logic [1:0] warm_q;
    logic       sel_stb;
    logic [4:0] cur;

    always_ff @(posedge clk_2x or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    always_comb begin
        cur = {src_sel, ratio_sel};
        case (src_sel)
            2'd0:    sel_stb = 1'b1;
            2'd1:    sel_stb = tick_1k;
            2'd2:    sel_stb = tick_32;
            default: sel_stb = tick_1;
        endcase
    end

    assert_released_R6: assert property (@(posedge clk_2x) disable iff (!rst_n)
        !ce_hi |-> (!fout_oe && !fout_data));

    assert_fixed_toggle_R7: assert property (@(posedge clk_2x) disable iff (!rst_n)
        (warm_q >= 2'd2 && ce_hi && !ctl_pin && $past(ce_hi) && !$past(ctl_pin))
        |-> (fout_oe && fout_data != $past(fout_data)));

    assert_enable_gate_R8: assert property (@(posedge clk_2x) disable iff (!rst_n)
        (ce_hi && ctl_pin) |-> (fout_oe == en_bit && fout_data == (en_bit & div_lvl)));

    assert_change_low_R9: assert property (@(posedge clk_2x) disable iff (!rst_n)
        (warm_q >= 2'd1 && cur != $past(cur)) |=> !div_lvl);

    assert_hold_no_strobe_R2: assert property (@(posedge clk_2x) disable iff (!rst_n)
        (warm_q >= 2'd1 && !sel_stb && cur == $past(cur)) |=> $stable(div_lvl));

endmodule

bind fout_divider fout_divider_chk i_chk (
    .clk_2x    (clk_2x),
    .rst_n     (rst_n),
    .tick_1k   (tick_1k),
    .tick_32   (tick_32),
    .tick_1    (tick_1),
    .src_sel   (src_sel),
    .ratio_sel (ratio_sel),
    .en_bit    (en_bit),
    .ctl_pin   (ctl_pin),
    .ce_hi     (ce_hi),
    .fout_data (fout_data),
    .fout_oe   (fout_oe),
    .div_lvl   (div_lvl)
);

// File: tb/test_fout_divider.sv
module test_fout_divider;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk_2x = 1'b0;
    logic       rst_n  = 1'b0;
    logic [1:0] src_sel   = 2'd0;
    logic [2:0] ratio_sel = 3'd0;
    logic       en_bit  = 1'b1;
    logic       ctl_pin = 1'b0;
    logic       ce_hi   = 1'b1;
    logic       man_1k = 1'b0, man_32 = 1'b0, man_1 = 1'b0;
    logic       g_1k = 1'b0, g_32 = 1'b0, g_1 = 1'b0;
    logic       gen_on = 1'b0;
    wire        tick_1k = gen_on ? g_1k : man_1k;
    wire        tick_32 = gen_on ? g_32 : man_32;
    wire        tick_1  = gen_on ? g_1  : man_1;
    wire        fout_data;
    wire        fout_oe;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    int  cyc = 0;
    int  gcnt = 0;
    int  m_sel, m_phase, m_div, m_fix;

    fout_divider i_fout_divider (
        .clk_2x(clk_2x), .rst_n(rst_n),
        .tick_1k(tick_1k), .tick_32(tick_32), .tick_1(tick_1),
        .src_sel(src_sel), .ratio_sel(ratio_sel), .en_bit(en_bit),
        .ctl_pin(ctl_pin), .ce_hi(ce_hi),
        .fout_data(fout_data), .fout_oe(fout_oe)
    );

    always #(CLK_PERIOD/2) clk_2x = ~clk_2x;

    function automatic int ref_ratio(input int code);
        case (code)
            0: return 1;  1: return 2;  2: return 3;  3: return 6;
            4: return 5;  5: return 10; 6: return 15; default: return 30;
        endcase
    endfunction

    function automatic int ref_high(input int code);
        int r = ref_ratio(code);
        if (code == 2 || code == 6) return (2 * r) / 3;
        if (code == 4) return (2 * r) / 5;
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic cyc_n(input int n);
        repeat (n) @(posedge clk_2x);
        #2;
    endtask

    // free-running strobes with unrelated spacings
    always @(posedge clk_2x) begin
        #2;
        gcnt++;
        g_1k = (gcnt % 3 == 0);
        g_32 = (gcnt % 7 == 2);
        g_1  = (gcnt % 13 == 5);
    end

    // behavioural reference model
    always @(posedge clk_2x) begin
        int cur;
        bit stb;
        cyc++;
        if (!rst_n) begin
            m_sel = 0; m_phase = 1; m_div = 0; m_fix = 0;
        end else begin
            cur = int'(src_sel) * 8 + int'(ratio_sel);
            case (src_sel)
                2'd0: stb = 1'b1;
                2'd1: stb = tick_1k;
                2'd2: stb = tick_32;
                default: stb = tick_1;
            endcase
            m_fix = 1 - m_fix;
            if (cur != m_sel) begin
                m_sel = cur;
                m_phase = 2 * ref_ratio(int'(ratio_sel)) - 1;
                m_div = 0;
            end else if (stb) begin
                m_phase = (m_phase + 1) % (2 * ref_ratio(int'(ratio_sel)));
                m_div = (m_phase < ref_high(int'(ratio_sel))) ? 1 : 0;
            end
        end
        if (cyc > WATCHDOG && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    // compare every clock, away from the edge
    always @(negedge clk_2x) begin
        int e_oe, e_d;
        string tag;
        if (rst_n && !done) begin
            if (!ce_hi) begin
                e_oe = 0; e_d = 0; tag = "R6";
            end else if (!ctl_pin) begin
                e_oe = 1; e_d = m_fix; tag = "R7";
            end else if (!en_bit) begin
                e_oe = 0; e_d = 0; tag = "R8";
            end else begin
                e_oe = 1; e_d = m_div;
                tag = (ratio_sel == 3'd2 || ratio_sel == 3'd4 || ratio_sel == 3'd6) ? "R5" : "R4";
            end
            chk({tag, " oe"}, int'(fout_oe), e_oe);
            chk({tag, " data"}, int'(fout_data), e_d);
        end
    end

    task automatic measure(input int code);
        int hi_n = 0;
        int lo_n = 0;
        int guard = 0;
        logic prev;
        ratio_sel = 3'(code);
        @(negedge clk_2x);
        prev = fout_data;
        while (guard < 200) begin
            @(negedge clk_2x);
            guard++;
            if (fout_data && !prev) break;
            prev = fout_data;
        end
        hi_n = 1;
        while (guard < 400) begin
            @(negedge clk_2x);
            guard++;
            if (fout_data) hi_n++; else break;
        end
        lo_n = 1;
        while (guard < 600) begin
            @(negedge clk_2x);
            guard++;
            if (!fout_data) lo_n++; else break;
        end
        chk($sformatf("R3 period of code %0d", code), hi_n + lo_n, 2 * ref_ratio(code));
        if (code == 2 || code == 4 || code == 6)
            chk($sformatf("R5 high part of code %0d", code), hi_n, ref_high(code));
        else
            chk($sformatf("R4 high part of code %0d", code), hi_n, ref_ratio(code));
        @(posedge clk_2x);
        #2;
    endtask

    task automatic pulse_1();
        man_1 = 1'b1;
        cyc_n(1);
        man_1 = 1'b0;
    endtask

    initial begin
        // R1: reset state
        cyc_n(3);
        chk("R1 fixed level in reset", int'(fout_data), 0);
        chk("R1 oe in reset", int'(fout_oe), 1);
        ctl_pin = 1'b1;
        #1;
        chk("R1 divided level in reset", int'(fout_data), 0);
        ctl_pin = 1'b0;
        rst_n = 1'b1;
        // R7: fixed wave while registers move
        gen_on = 1'b1;
        for (int i = 0; i < 8; i++) begin
            src_sel = 2'(i % 4);
            ratio_sel = 3'(7 - i);
            en_bit = i[0];
            cyc_n(5);
        end
        // R6: released
        ce_hi = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ctl_pin = i[0];
            en_bit = i[1];
            cyc_n(4);
        end
        ce_hi = 1'b1;
        ctl_pin = 1'b1;
        en_bit = 1'b0;
        cyc_n(6);
        en_bit = 1'b1;
        // R3, R4, R5 on the base source
        src_sel = 2'd0;
        for (int c = 0; c < 8; c++) measure(c);
        // sweep every source and ratio with free strobes
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 8; c++) begin
                src_sel = 2'(s);
                ratio_sel = 3'(c);
                cyc_n(120);
                ctl_pin = 1'b0; cyc_n(6);
                ce_hi = 1'b0;   cyc_n(6);
                ce_hi = 1'b1; ctl_pin = 1'b1; en_bit = 1'b0; cyc_n(6);
                en_bit = 1'b1;
            end
        end
        // R2: strobes of other sources ignored
        gen_on = 1'b0;
        src_sel = 2'd1;
        ratio_sel = 3'd0;
        cyc_n(3);
        man_1k = 1'b1; cyc_n(1); man_1k = 1'b0;
        chk("R2 selected strobe advances", int'(fout_data), 1);
        for (int i = 0; i < 4; i++) begin
            man_32 = 1'b1; man_1 = 1'b1; cyc_n(1);
            man_32 = 1'b0; man_1 = 1'b0; cyc_n(1);
        end
        chk("R2 foreign strobes ignored", int'(fout_data), 1);
        man_1k = 1'b1; cyc_n(1); man_1k = 1'b0;
        chk("R2 selected strobe advances again", int'(fout_data), 0);
        // R9: change and strobe in the same cycle
        src_sel = 2'd3;
        ratio_sel = 3'd1;
        cyc_n(3);
        pulse_1(); chk("R9 setup high", int'(fout_data), 1);
        pulse_1(); chk("R9 setup high 2", int'(fout_data), 1);
        pulse_1(); chk("R9 setup low", int'(fout_data), 0);
        pulse_1(); chk("R9 setup low 2", int'(fout_data), 0);
        pulse_1(); chk("R9 setup high 3", int'(fout_data), 1);
        ratio_sel = 3'd0;
        man_1 = 1'b1;
        cyc_n(1);
        man_1 = 1'b0;
        chk("R9 level forced low", int'(fout_data), 0);
        cyc_n(4);
        chk("R9 coincident strobe discarded", int'(fout_data), 0);
        pulse_1(); chk("R9 fresh period starts high", int'(fout_data), 1);
        // R10: ratio 1 on a slow source
        cyc_n(3);
        chk("R10 holds between strobes", int'(fout_data), 1);
        pulse_1(); chk("R10 low after strobe", int'(fout_data), 0);
        cyc_n(3);
        pulse_1(); chk("R10 high after strobe", int'(fout_data), 1);
        src_sel = 2'd2;
        cyc_n(2);
        for (int i = 0; i < 4; i++) begin
            man_32 = 1'b1; cyc_n(1); man_32 = 1'b0;
            chk("R10 32 Hz alternation", int'(fout_data), (i % 2 == 0) ? 1 : 0);
            cyc_n(2);
        end
        cyc_n(2);
        finish_run();
    end

endmodule